// File: doc/BRIEF.md
# Program/Erase Status Polling Unit

This block forms the byte that a host sees on the data bus while an automatic program or erase operation runs in the memory behind it. While the operation engine reports busy, the top bit of the byte carries a completion indicator, and the bit below it toggles on every completed host read. All remaining bits read as zero. Once the engine drops busy, the byte passes the array data through unchanged.

The operation engine pulses `start_i` on the cycle that launches an operation, which is the rising edge of the second write of a two-write command. On that pulse the unit captures the kind of operation and the top bit of the byte being written, and it clears the toggle bit. Host software polls by reading twice. It treats the operation as finished when bit 6 matches across the two reads and bit 7 has reached its final value.

Top module: `status_poll_unit`

## Requirements
- R1: After reset the captured kind is program, the captured top data bit is 0 and the toggle bit is 0. If busy is raised with no start pulse, the bus therefore reads 8'h80.
- R2: While busy after a program start, bit 7 of `data_o` is the inverse of bit 7 of the `prog_data_i` value captured at the start pulse.
- R3: While busy after an erase start (`op_erase_i` = 1 at the start pulse), bit 7 of `data_o` is 0.
- R4: While `busy_i` is 0, `data_o` equals `array_data_i` in the same cycle.
- R5: A completed read flips bit 6 while busy. A completed read is the cycle in which `chip_sel_i` and `out_en_i` stop being both 1 after having both been 1. The new value shows from the clock edge at which the strobe is seen low. A cycle with only one of the two enables high is not a read.
- R6: With busy low, reads leave the toggle bit unchanged. The held value shows on bit 6 when busy is next raised without a start pulse.
- R7: A start pulse clears the toggle bit to 0 from the next clock edge, even when a completed read lands in the same cycle.
- R8: While busy, bits 5 to 0 of `data_o` are 0, whatever `array_data_i` holds.
- R9: `op_erase_i` and `prog_data_i` are sampled only in the start pulse cycle. Changes to them at any other time do not alter bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse at operation launch |
| busy_i | input | 1 | Operation engine busy |
| op_erase_i | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_data_i | input | 8 | Byte being programmed |
| chip_sel_i | input | 1 | Chip enable, active high |
| out_en_i | input | 1 | Output enable, active high |
| array_data_i | input | 8 | Data read from the array |
| data_o | output | 8 | Byte driven to the host bus |

## Verification
The assertions check several rules on every cycle: the masking of bits 5 to 0, the value of bit 7 for each kind of operation, the pass-through when idle, the clearing of the toggle bit on start, and its single flip per completed read. Only the bench scenarios can show what a polling host actually observes. That covers alternation across successive reads, a toggle value held through idle reads and seen again when busy returns without a start, and the fact that input changes after the start pulse cannot disturb bit 7. The sweep runs every program byte under both operation kinds.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic {OP_PROGRAM = 1'b0, OP_ERASE = 1'b1} op_kind_e;
endpackage

// File: rtl/spu_strobe_edge.sv
module spu_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_sel_i,
  input  logic out_en_i,
  output logic fall_o
);
  logic rd_now, rd_q;
  assign rd_now = chip_sel_i & out_en_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_now;

  assign fall_o = rd_q & ~rd_now;
endmodule

// File: rtl/spu_op_latch.sv
module spu_op_latch #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                op_erase_i,
  input  logic [DATA_W-1:0]   prog_data_i,
  output spu_pkg::op_kind_e   kind_o,
  output logic                prog_bit_o
);
  import spu_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      kind_o     <= OP_PROGRAM;
      prog_bit_o <= 1'b0;
    end else if (start_i) begin
      kind_o     <= op_erase_i ? OP_ERASE : OP_PROGRAM;
      prog_bit_o <= prog_data_i[POLL_BIT];
    end

  assert_kind_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(kind_o) && $stable(prog_bit_o)));
endmodule

// File: rtl/spu_toggle.sv
module spu_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  input  logic fall_i,
  output logic tgl_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               tgl_o <= 1'b0;
    else if (start_i)          tgl_o <= 1'b0;
    else if (busy_i && fall_i) tgl_o <= ~tgl_o;

  assert_tgl_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !tgl_o);
  assert_tgl_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && busy_i && fall_i) |=> (tgl_o != $past(tgl_o)));
  assert_tgl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !(busy_i && fall_i)) |=> $stable(tgl_o));
endmodule

// File: rtl/spu_bus_mux.sv
module spu_bus_mux #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              busy_i,
  input  spu_pkg::op_kind_e kind_i,
  input  logic              prog_bit_i,
  input  logic              tgl_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] data_o
);
  import spu_pkg::*;
  logic poll_bit;
  assign poll_bit = (kind_i == OP_ERASE) ? 1'b0 : ~prog_bit_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign data_o[i] = busy_i ? poll_bit : array_data_i[i];
    end else if (i == TOGGLE_BIT) begin : g_tgl
      assign data_o[i] = busy_i ? tgl_i : array_data_i[i];
    end else begin : g_zero
      assign data_o[i] = busy_i ? 1'b0 : array_data_i[i];
    end
  end
endmodule

// File: rtl/status_poll_unit.sv
module status_poll_unit #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              chip_sel_i,
  input  logic              out_en_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] data_o
);
  import spu_pkg::*;
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

  logic     fall, tgl, prog_bit;
  op_kind_e kind;

  spu_strobe_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .chip_sel_i(chip_sel_i),
    .out_en_i(out_en_i), .fall_o(fall));

  spu_op_latch #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_erase_i(op_erase_i),
    .prog_data_i(prog_data_i), .kind_o(kind), .prog_bit_o(prog_bit));

  spu_toggle u_tgl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy_i),
    .fall_i(fall), .tgl_o(tgl));

  spu_bus_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_mux (
    .busy_i(busy_i), .kind_i(kind), .prog_bit_i(prog_bit), .tgl_i(tgl),
    .array_data_i(array_data_i), .data_o(data_o));

  assert_low_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ((data_o & ~STATUS_MASK) == '0));
  assert_idle_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (data_o == array_data_i));
  assert_erase_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && kind == OP_ERASE) |-> !data_o[POLL_BIT]);
  assert_prog_poll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && kind == OP_PROGRAM) |-> (data_o[POLL_BIT] == !prog_bit));
endmodule

// File: tb/status_poll_unit_test.sv
module status_poll_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, busy = 1'b0, op_erase = 1'b0;
  logic [7:0] prog_data = '0, array_data = '0;
  logic       cs = 1'b0, oe = 1'b0;
  logic [7:0] data;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;
  logic       exp_tgl;

  always #2 clk = ~clk;

  status_poll_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_i(busy),
    .op_erase_i(op_erase), .prog_data_i(prog_data), .chip_sel_i(cs),
    .out_en_i(oe), .array_data_i(array_data), .data_o(data));

  task automatic check(input string req, input logic [7:0] exp);
    n_cmp++;
    if (data !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, data, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input logic erase, input logic [7:0] b,
                                            input logic t);
    return {erase ? 1'b0 : ~b[7], t, 6'b0};
  endfunction

  task automatic host_read(input logic erase, input logic [7:0] b, input string req);
    @(negedge clk); cs = 1'b1; oe = 1'b1; #1;
    if (busy) check(req, status_exp(erase, b, exp_tgl));
    @(negedge clk); cs = 1'b0; oe = 1'b0;
    @(negedge clk); if (busy) exp_tgl = ~exp_tgl; #1;
    if (busy) check({req, " R5 flip"}, status_exp(erase, b, exp_tgl));
    else      check({req, " R4 idle"}, array_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen by raising busy without start
    @(negedge clk); array_data = 8'h3C; #1; check("R1 idle", 8'h3C);
    busy = 1'b1; #1; check("R1 reset state", 8'h80);
    busy = 1'b0;
    exp_tgl = 1'b0;

    for (int op = 0; op < 2; op++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        start = 1'b1; busy = 1'b1; op_erase = op[0]; prog_data = b[7:0];
        @(negedge clk);
        start = 1'b0; op_erase = ~op[0]; prog_data = ~b[7:0];  // R9 disturbance
        array_data = 8'(b * 37 + 5);
        exp_tgl = 1'b0; #1;
        check(op[0] ? "R3 R7 R8 start" : "R2 R7 R8 start", status_exp(op[0], b[7:0], 1'b0));
        for (int r = 0; r < 3; r++)
          host_read(op[0], b[7:0], op[0] ? "R3 R9" : "R2 R9");
        if (b % 4 == 0) begin
          // one enable only: not a read
          @(negedge clk); cs = 1'b1; oe = 1'b0;
          @(negedge clk); cs = 1'b0; oe = 1'b1;
          @(negedge clk); oe = 1'b0;
          @(negedge clk); #1;
          check("R5 single enable", status_exp(op[0], b[7:0], exp_tgl));
        end
        @(negedge clk); busy = 1'b0; array_data = 8'(b) ^ 8'h5A; #1;
        check("R4 done", array_data);
        host_read(op[0], b[7:0], "R6 idle read");
        @(negedge clk); busy = 1'b1; #1;
        check("R6 held toggle R9", status_exp(op[0], b[7:0], exp_tgl));
        @(negedge clk); busy = 1'b0; #1;
        check("R4 back idle", array_data);
      end
    end

    // R7: start coincides with a completed read
    @(negedge clk); start = 1'b1; busy = 1'b1; op_erase = 1'b0; prog_data = 8'h00;
    @(negedge clk); start = 1'b0; exp_tgl = 1'b0;
    host_read(1'b0, 8'h00, "R7 setup");
    @(negedge clk); cs = 1'b1; oe = 1'b1;
    @(negedge clk); cs = 1'b0; oe = 1'b0; start = 1'b1; prog_data = 8'hFF;
    @(negedge clk); start = 1'b0; #1;
    check("R7 start beats read", status_exp(1'b0, 8'hFF, 1'b0));
    @(negedge clk); busy = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule